// File: doc/BRIEF.md
# I2C Controller Bit-Timing Engine

This block times one bit at a time on the clock and data lines of an I2C controller. A shared prescaler divides the kernel clock into a timing tick. Four phase counters run on that tick: the SCL low length, the SCL high length, the delay from the SCL falling edge to the SDA update, and the delay from the SDA update to the SCL release. The two lines are open drain. Each output here is a pull-down enable, where 1 means the block drives the line low.

When the block is idle and a bit request arrives, it pulls SCL low at once. After the SDA delay it sets the SDA pull-down to the inverse of the bit value. It keeps SCL low until two things are true: the low count has run out, and the SCL delay has run out after the SDA update. It then releases SCL and waits until the sensed SCL line reads high, so that a target holding the clock low (clock stretching) is respected. It counts the high phase from that point and then pulses a done strobe. SDA keeps its value until the next bit updates it. Byte framing, start and stop sequencing and arbitration belong to the layer above.

The states are:
- IDLE: SCL released, waiting for a request.
- SETUP: SCL low, waiting for the SDA delay.
- LAUNCH: SCL low, SDA updated, waiting for the SCL delay.
- TAIL: SCL low, waiting for the remaining low count.
- SYNC: SCL released, waiting to see the line high.
- HIGH: counting the high phase.

The transitions are:
- IDLE→SETUP when a request arrives.
- SETUP→LAUNCH when the SDA delay expires.
- LAUNCH→SYNC when the SCL delay expires and the low count is already done.
- LAUNCH→TAIL when the SCL delay expires and the low count is not yet done.
- TAIL→SYNC when the low count expires.
- SYNC→HIGH when the SCL line is sensed high.
- HIGH→IDLE when the high count expires, which also raises the done strobe.
- Any state→IDLE when enable is low.

Top module: `i2c_bit_timer`

## Requirements
- R1: The tick period is P = D + 1 kernel clocks, where D = {div_hi, div_lo}, an 8-bit value with div_hi as its upper nibble. Every phase below is a whole number of ticks, counted from the phase start.
- R2: A request accepted in IDLE sets scl_oe to 1 in the next cycle. sda_oe then takes the value !bit_val exactly (sda_delay+1)·P cycles after the accepting edge, and changes only while scl_oe is 1.
- R3: scl_oe falls to 0 exactly max(scl_low_len+1, sda_delay+scl_delay+2)·P cycles after the accepting edge.
- R4: When the low count and the SCL delay expire on the same tick, SCL is released on that tick, with no extra tick added.
- R5: After release, the high phase starts on the edge after scl_in is sampled high. While scl_in stays low (stretching), the block waits in SYNC for as long as it takes.
- R6: bit_done is a one-cycle pulse. It appears (scl_high_len+1)·P cycles after the edge that starts the high phase, and the block is then idle with scl_oe at 0.
- R7: sda_oe keeps its value through the high phase and through idle time until the next SDA update.
- R8: While en is low, scl_oe and sda_oe are 0 in the same cycle, without waiting for a clock edge. At the next edge all counters restart, and requests are ignored. After en returns, the next bit is timed exactly as from reset.
- R9: bit_req is ignored while a bit is in progress.
- R10: A request raised in the cycle where bit_done is 1 is accepted at the next edge, with no gap cycle.
- R11: After reset, scl_oe, sda_oe and bit_done are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| div_hi | input | 4 | Upper nibble of the prescaler value |
| div_lo | input | 4 | Lower nibble of the prescaler value |
| scl_low_len | input | 8 | SCL low count, phase = value+1 ticks |
| scl_high_len | input | 8 | SCL high count, phase = value+1 ticks |
| sda_delay | input | 4 | Ticks-1 from the SCL fall to the SDA update |
| scl_delay | input | 4 | Ticks-1 from the SDA update to the SCL release |
| bit_req | input | 1 | Request to send one bit |
| bit_val | input | 1 | Bit value, latched when the request is accepted |
| scl_in | input | 1 | Sensed SCL line level, synchronous to clk |
| scl_oe | output | 1 | SCL pull-down enable (1 = drive low) |
| sda_oe | output | 1 | SDA pull-down enable (1 = drive low) |
| bit_done | output | 1 | One-cycle strobe at the end of a bit |

## Verification
The low-count expiry and the SCL-delay expiry can land on the same tick. The bench provokes this by choosing scl_low_len+1 equal to sda_delay+scl_delay+2, and checks that scl_oe falls exactly at that tick rather than one tick later. The end of one bit and the acceptance of the next can also coincide. The bench raises bit_req in the very cycle bit_done shows, and checks on every clock against its own model that SCL drops in the following cycle with no idle gap.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LAUNCH,
        ST_TAIL,
        ST_SYNC,
        ST_HIGH
    } bt_state_t;

endpackage

// File: rtl/i2c_tick_gen.sv
module i2c_tick_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = !clr && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_phase_cnt.sv
module i2c_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit,
    output logic         expired
);
    logic [W-1:0] cnt_q;
    logic         done_q;

    assign hit     = run && !done_q && (cnt_q == limit);
    assign expired = done_q || hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (hit) begin
            done_q <= 1'b1;
        end else if (run && !done_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
    import i2c_bt_pkg::*;
#(
    parameter int DIV_NW = 4,
    parameter int LEN_W  = 8,
    parameter int DLY_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_NW-1:0] div_hi,
    input  logic [DIV_NW-1:0] div_lo,
    input  logic [LEN_W-1:0] scl_low_len,
    input  logic [LEN_W-1:0] scl_high_len,
    input  logic [DLY_W-1:0] sda_delay,
    input  logic [DLY_W-1:0] scl_delay,
    input  logic             bit_req,
    input  logic             bit_val,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             bit_done
);
    localparam int DIV_W   = 2 * DIV_NW;
    localparam int N_DLY   = 2;

    bt_state_t state_q, state_d;

    logic             in_low;
    logic             tick;
    logic [DIV_W-1:0] div_val;
    logic             bit_lat_q;
    logic             sda_drv_q;
    logic             done_q;

    logic             low_hit, low_exp;
    logic             high_hit, high_exp;
    logic [N_DLY-1:0] dly_clr, dly_run, dly_hit, dly_exp;
    logic [DLY_W-1:0] dly_lim [N_DLY];

    assign div_val = {div_hi, div_lo};
    assign in_low  = (state_q == ST_SETUP) || (state_q == ST_LAUNCH) ||
                     (state_q == ST_TAIL);

    i2c_tick_gen #(.W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!en || state_q == ST_IDLE || state_q == ST_SYNC),
        .div  (div_val),
        .tick (tick)
    );

    i2c_phase_cnt #(.W(LEN_W)) u_low (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!en || state_q == ST_IDLE),
        .run    (tick && in_low),
        .limit  (scl_low_len),
        .hit    (low_hit),
        .expired(low_exp)
    );

    i2c_phase_cnt #(.W(LEN_W)) u_high (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!en || state_q != ST_HIGH),
        .run    (tick && state_q == ST_HIGH),
        .limit  (scl_high_len),
        .hit    (high_hit),
        .expired(high_exp)
    );

    // index 0: SDA delay (runs in SETUP), index 1: SCL delay (runs in LAUNCH)
    assign dly_lim[0] = sda_delay;
    assign dly_lim[1] = scl_delay;
    assign dly_clr[0] = !en || state_q == ST_IDLE;
    assign dly_clr[1] = !en || state_q != ST_LAUNCH;
    assign dly_run[0] = tick && state_q == ST_SETUP;
    assign dly_run[1] = tick && state_q == ST_LAUNCH;

    for (genvar g = 0; g < N_DLY; g++) begin : g_dly
        i2c_phase_cnt #(.W(DLY_W)) u_dly (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (dly_clr[g]),
            .run    (dly_run[g]),
            .limit  (dly_lim[g]),
            .hit    (dly_hit[g]),
            .expired(dly_exp[g])
        );
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (bit_req)    state_d = ST_SETUP;
                ST_SETUP:  if (dly_hit[0]) state_d = ST_LAUNCH;
                ST_LAUNCH: if (dly_hit[1]) state_d = low_exp ? ST_SYNC : ST_TAIL;
                ST_TAIL:   if (low_exp)    state_d = ST_SYNC;
                ST_SYNC:   if (scl_in)     state_d = ST_HIGH;
                ST_HIGH:   if (high_hit)   state_d = ST_IDLE;
                default:                   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // data registers tied to transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_lat_q <= 1'b0;
            sda_drv_q <= 1'b0;
            done_q    <= 1'b0;
        end else if (!en) begin
            sda_drv_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= (state_q == ST_HIGH) && high_hit;
            if (state_q == ST_IDLE && bit_req) begin
                bit_lat_q <= bit_val;
            end
            if (state_q == ST_SETUP && dly_hit[0]) begin
                sda_drv_q <= !bit_lat_q;
            end
        end
    end

    // outputs
    always_comb begin
        scl_oe   = en && in_low;
        sda_oe   = en && sda_drv_q;
        bit_done = done_q;
    end

    logic unused_exp;
    assign unused_exp = high_exp ^ (^dly_exp);
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk
    import i2c_bt_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      en,
    input logic      scl_in,
    input logic      scl_oe,
    input logic      sda_oe,
    input logic      bit_done,
    input bt_state_t state
);
    // R8
    en_low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!scl_oe && !sda_oe));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |=> !bit_done);

    // R2
    sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (sda_oe != $past(sda_oe))) |-> scl_oe);

    // R7
    sda_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

    // R5
    stretch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_SYNC && !scl_in) |=> (state == ST_SYNC));
endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .scl_in  (scl_in),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .bit_done(bit_done),
    .state   (state_q)
);

// File: tb/tb_i2c_bit_timer.sv
`timescale 1ns/1ps
module tb_i2c_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic [3:0] dhi = '0, dlo = '0, sdad = '0, scld = '0;
    logic [7:0] scll = '0, sclh = '0;
    logic       req = 1'b0, val = 1'b0, stretch = 1'b0;
    logic       scl_in, scl_oe, sda_oe, bit_done;

    int    checks = 0, fails = 0;
    string tag = "R11";

    // behavioural reference state
    int m_phase = 0, m_cnt = 0, m_h = 0;
    bit m_sda = 0, m_bit = 0, m_done = 0;

    always #2 clk = ~clk;

    assign scl_in = !scl_oe && !stretch;

    i2c_bit_timer dut (
        .clk(clk), .rst_n(rst_n), .en(en), .div_hi(dhi), .div_lo(dlo),
        .scl_low_len(scll), .scl_high_len(sclh), .sda_delay(sdad),
        .scl_delay(scld), .bit_req(req), .bit_val(val), .scl_in(scl_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .bit_done(bit_done)
    );

    function automatic int per();
        return int'(dhi) * 16 + int'(dlo) + 1;
    endfunction

    function automatic int t_rel();
        int a = int'(scll) + 1;
        int b = int'(sdad) + int'(scld) + 2;
        return ((a > b) ? a : b) * per();
    endfunction

    task automatic model_step();
        if (!rst_n || !en) begin
            m_phase = 0; m_sda = 0; m_done = 0;
        end else begin
            m_done = 0;
            case (m_phase)
                0: if (req) begin m_phase = 1; m_cnt = 0; m_bit = val; end
                1: begin
                    m_cnt++;
                    if (m_cnt == (int'(sdad) + 1) * per()) m_sda = !m_bit;
                    if (m_cnt == t_rel()) m_phase = 2;
                end
                2: if (!stretch) begin m_phase = 3; m_h = 0; end
                default: begin
                    m_h++;
                    if (m_h == (int'(sclh) + 1) * per()) begin m_phase = 0; m_done = 1; end
                end
            endcase
        end
    endtask

    task automatic check(input logic act, input logic exp, input string name);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
            model_step();
            check(scl_oe, en && m_phase == 1, "scl_oe");
            check(sda_oe, en && m_sda, "sda_oe");
            check(bit_done, m_done, "bit_done");
        end
    endtask

    task automatic wait_done();
        for (int g = 0; g < 20000 && !m_done; g++) cyc(1);
    endtask

    task automatic run_bit(input logic v);
        req = 1'b1; val = v;
        cyc(1);
        req = 1'b0;
        wait_done();
    endtask

    task automatic cfg(input logic [3:0] h, input logic [3:0] l, input logic [7:0] lo,
                       input logic [7:0] hi, input logic [3:0] sd, input logic [3:0] cd);
        dhi = h; dlo = l; scll = lo; sclh = hi; sdad = sd; scld = cd;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R11: reset state
        tag = "R11";
        cyc(3);
        rst_n = 1'b1;
        cyc(3);

        // R2 R3: undivided tick, low count dominates
        tag = "R2";
        cfg(4'h0, 4'h0, 8'd5, 8'd4, 4'd1, 4'd1);
        run_bit(1'b0);
        tag = "R3";
        run_bit(1'b1);

        // R1: divided tick, D = 0x12
        tag = "R1";
        cfg(4'h1, 4'h2, 8'd2, 8'd1, 4'd0, 4'd0);
        run_bit(1'b0);

        // R4: low count and SCL delay end on the same tick
        tag = "R4";
        cfg(4'h0, 4'h2, 8'd4, 8'd2, 4'd1, 4'd2);
        run_bit(1'b1);
        run_bit(1'b0);

        // R3: delays dominate the low phase
        tag = "R3";
        cfg(4'h0, 4'h1, 8'd0, 8'd3, 4'd3, 4'd5);
        run_bit(1'b1);

        // R7: SDA held through idle time
        tag = "R7";
        cfg(4'h0, 4'h0, 8'd3, 8'd3, 4'd0, 4'd0);
        run_bit(1'b0);
        cyc(20);

        // R5: clock stretching holds the high phase
        tag = "R5";
        cfg(4'h0, 4'h1, 8'd3, 8'd2, 4'd0, 4'd1);
        stretch = 1'b1; req = 1'b1; val = 1'b1;
        cyc(1);
        req = 1'b0;
        for (int g = 0; g < 1000 && m_phase != 2; g++) cyc(1);
        cyc(12);
        stretch = 1'b0;
        wait_done();

        // R9: request during a bit is ignored
        tag = "R9";
        cfg(4'h0, 4'h0, 8'd6, 8'd3, 4'd1, 4'd1);
        req = 1'b1; val = 1'b0;
        cyc(1);
        req = 1'b0;
        cyc(3);
        req = 1'b1; val = 1'b1;
        cyc(2);
        req = 1'b0;
        wait_done();
        cyc(4);

        // R10: back-to-back request in the done cycle
        tag = "R10";
        run_bit(1'b1);
        req = 1'b1; val = 1'b0;
        cyc(1);
        req = 1'b0;
        wait_done();
        req = 1'b1; val = 1'b1;
        cyc(1);
        req = 1'b0;
        wait_done();

        // R8: enable drop releases lines at once and restarts counters
        tag = "R8";
        cfg(4'h0, 4'h0, 8'd9, 8'd3, 4'd0, 4'd0);
        req = 1'b1; val = 1'b0;
        cyc(1);
        req = 1'b0;
        cyc(4);
        check(scl_oe, 1'b1, "scl_oe before disable");
        check(sda_oe, 1'b1, "sda_oe before disable");
        en = 1'b0;
        #1;
        check(scl_oe, 1'b0, "scl_oe released same cycle");
        check(sda_oe, 1'b0, "sda_oe released same cycle");
        req = 1'b1;
        cyc(5);
        req = 1'b0;
        en = 1'b1;
        cyc(3);
        run_bit(1'b0);
        cyc(3);

        summary();
        $finish;
    end
endmodule